// File: doc/BRIEF.md
# Pipelined Register-Only Matrix Transposer

This block turns a stream of row vectors into a stream of column vectors of the same square matrix. It sits between the first and second one-dimensional passes of a separable two-dimensional transform. Every valid cycle it takes one row of N words in parallel. After a fixed fill delay it gives back one column of N words per cycle. Because it holds no RAM, consecutive matrices can follow one another with no idle cycle between them.

Two banks of lane shift registers do the reordering, with a row of N-to-1 selectors between them. The entry bank delays input lane j by j+1 cycles. Each selector output k picks one entry-bank lane. The exit bank delays selector output k by N-k cycles. The select value is a row count taken modulo N. It is registered once for selector 0, and each later selector sees it through one more delay element. Selector k therefore works k cycles after selector 0. The skew means each selector reads its own word of a given row in its own cycle, so no single row ever has to give out more than one word in the same cycle.

A two-state frame tracker drives the row count. In state ST_EDGE the next valid row is row 0 of a new matrix; the transition EDGE_TO_MID fires on that valid row. In state ST_MID the count climbs by one on each valid row. On the valid row numbered N-1 the transition MID_TO_EDGE takes the tracker back to ST_EDGE. A cycle without a valid row changes neither the state nor the count.

Top module: `skew_transposer`

## Requirements
- R1: While reset is asserted, and after its release until the first valid row has travelled through, out_valid is 0.
- R2: out_valid equals in_valid delayed by exactly N+1 clock cycles (fill latency N+1 = 9 for N=8).
- R3: The input row is packed with word j at bits [j*W +: W]. For the column output in cycle t0+N+1+j, where t0 is the cycle of row 0 of that matrix, word i of out_col at bits [i*W +: W] equals word j of row i.
- R4: The N columns of one matrix appear in order 0, 1, …, N-1 on N consecutive cycles.
- R5: With one valid row every cycle, matrices stream back to back. Column 0 of the next matrix directly follows column N-1 of the previous one, and out_valid stays high.
- R6: The row count advances modulo N only on valid cycles. Idle cycles between whole matrices, and whatever data sits on in_row during them, have no effect on any later column.
- R7: Reset during a partly received matrix drops that matrix: it produces no column. The next matrix after reset starts at row 0 and transposes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_row carries a matrix row this cycle |
| in_row | input | N*W | Row vector, word j at bits [j*W +: W] |
| out_valid | output | 1 | out_col carries a matrix column this cycle |
| out_col | output | N*W | Column vector, word i (from row i) at bits [i*W +: W] |

## Verification
In a zero-gap stream, the selectors read two matrices in the same cycle. The low selectors already take words of the next matrix, while the high selectors still finish columns of the previous one. This is provoked by feeding matrices with no idle cycle between them. It is judged by comparing every output column with a bench-side transpose, and by comparing its arrival cycle with the cycle of its source row plus N+1. The test also feeds gaps filled with junk data, all-zero and all-ones matrices, and a reset in the middle of a matrix.

// File: rtl/skewtr_pkg.sv
package skewtr_pkg;

    // Frame tracker: ST_EDGE waits for row 0, ST_MID is inside a matrix.
    typedef enum logic [0:0] {
        ST_EDGE = 1'b0,
        ST_MID  = 1'b1
    } frame_state_t;

endpackage

// File: rtl/skewtr_bank.sv
// One bank of per-lane shift registers. The depth is lane+1 when ASCEND is
// set, and N-lane when it is clear.
module skewtr_bank #(
    parameter int N      = 8,
    parameter int W      = 16,
    parameter bit ASCEND = 1'b1
) (
    input  logic           clk,
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);

    for (genvar ln = 0; ln < N; ln++) begin : g_lane
        localparam int DEPTH = ASCEND ? (ln + 1) : (N - ln);
        logic [W-1:0] pipe_q [DEPTH];

        always_ff @(posedge clk) begin
            pipe_q[0] <= din[ln*W +: W];
            for (int s = 1; s < DEPTH; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end

        assign dout[ln*W +: W] = pipe_q[DEPTH-1];
    end

endmodule

// File: rtl/skewtr_ctrl.sv
// Frame tracker, selector delay chain and valid pipeline.
module skewtr_ctrl
    import skewtr_pkg::*;
#(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic [N*SW-1:0] sel_bus,
    output logic            out_valid
);

    localparam int           LAT  = N + 1;
    localparam logic [SW-1:0] LAST = SW'(N - 1);

    frame_state_t  state_q, state_d;
    logic [SW-1:0] row_q, row_d;
    logic [SW-1:0] sel_q [N];
    logic [LAT-1:0] vld_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EDGE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    // Next state: EDGE_TO_MID on row 0, MID_TO_EDGE on row N-1
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            ST_EDGE: begin
                if (in_valid) begin
                    state_d = ST_MID;
                    row_d   = SW'(1);
                end
            end
            ST_MID: begin
                if (in_valid) begin
                    if (row_q == LAST) begin
                        state_d = ST_EDGE;
                        row_d   = '0;
                    end else begin
                        row_d = row_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_EDGE;
                row_d   = '0;
            end
        endcase
    end

    // Outputs: selector k sees the row count k+1 cycles late; valid delayed N+1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) sel_q[k] <= '0;
            vld_q <= '0;
        end else begin
            sel_q[0] <= row_q;
            for (int k = 1; k < N; k++) sel_q[k] <= sel_q[k-1];
            vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_sel
        assign sel_bus[k*SW +: SW] = sel_q[k];
    end
    assign out_valid = vld_q[LAT-1];

    // R6: the count steps modulo N on a valid row
    assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> row_q == (($past(row_q) == LAST) ? '0 : $past(row_q) + 1'b1));

    // R6: idle cycles leave the count alone
    assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(row_q) && $stable(state_q));

    // R6: ST_EDGE exactly when the next row is row 0
    assert_state_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EDGE) == (row_q == '0));

endmodule

// File: rtl/skew_transposer.sv
module skew_transposer #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_row,
    output logic           out_valid,
    output logic [N*W-1:0] out_col
);

    localparam int SW      = (N > 1) ? $clog2(N) : 1;
    localparam int LATENCY = N + 1;
    localparam int OW      = $clog2(LATENCY + 2) + 1;

    logic [N*W-1:0]  entry_bus;
    logic [N*W-1:0]  mux_bus;
    logic [N*SW-1:0] sel_bus;

    skewtr_bank #(.N(N), .W(W), .ASCEND(1'b1)) u_entry (
        .clk  (clk),
        .din  (in_row),
        .dout (entry_bus)
    );

    skewtr_ctrl #(.N(N), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sel_bus   (sel_bus),
        .out_valid (out_valid)
    );

    for (genvar k = 0; k < N; k++) begin : g_mux
        assign mux_bus[k*W +: W] = entry_bus[sel_bus[k*SW +: SW]*W +: W];
    end

    skewtr_bank #(.N(N), .W(W), .ASCEND(1'b0)) u_exit (
        .clk  (clk),
        .din  (mux_bus),
        .dout (out_col)
    );

    // Checker state: rows seen and rows still in flight
    logic          seen_q;
    logic [OW-1:0] inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            inflight_q <= '0;
        end else begin
            if (in_valid) seen_q <= 1'b1;
            unique case ({in_valid, out_valid})
                2'b10:   inflight_q <= inflight_q + 1'b1;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    // R1: no column before any row has entered
    assert_quiet_until_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !out_valid);

    // R2: each column matches a row still in flight
    assert_no_orphan_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight_q != '0);

    // R2: never more rows in flight than the fill latency
    assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= OW'(LATENCY));

endmodule

// File: tb/skew_transposer_test.sv
module skew_transposer_test;

    localparam int N    = 8;
    localparam int W    = 16;
    localparam int NMAT = 7;
    localparam int NCOL = NMAT * N;
    localparam int LAT  = N + 1;

    // Stimulus table: seed per matrix (0 = all zero, 1 = all ones) and idle gap after it.
    // Matrix 6 is sent after a reset in the middle of a matrix.
    localparam int unsigned SEED [NMAT] = '{32'h1234, 32'h0, 32'hBEEF, 32'h1, 32'h77, 32'h5A5A, 32'h99};
    localparam int          GAP  [NMAT] = '{0, 2, 0, 0, 5, 0, 0};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_row = '0;
    logic           out_valid;
    logic [N*W-1:0] out_col;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int col_cnt = 0;
    int in_cyc_of [NCOL];
    logic [W-1:0] mats [NMAT][N][N];

    skew_transposer #(.N(N), .W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_row    (in_row),
        .out_valid (out_valid),
        .out_col   (out_col)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] elem(int unsigned seed, int i, int j);
        int unsigned h;
        if (seed == 0) return '0;
        if (seed == 1) return '1;
        h = seed * 32'h9E3779B1 + i * 32'h85EBCA6B + j * 32'hC2B2AE35;
        h = h ^ (h >> 15);
        h = h * 32'h27D4EB2D;
        h = h ^ (h >> 13);
        return h[W-1:0];
    endfunction

    task automatic check(bit ok, string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_rows(int m, int nrows, bit record);
        for (int i = 0; i < nrows; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int j = 0; j < N; j++) in_row[j*W +: W] = mats[m][i][j];
            if (record) in_cyc_of[m*N + i] = cyc;
        end
    endtask

    task automatic idle(int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_row   = {N{16'hDEAD}} ^ {(N*W/32){cyc[31:0]}};
        end
    endtask

    // Monitor: R3 contents, R4 order, R2/R5 arrival cycle
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (col_cnt < NCOL) begin
                automatic int m = col_cnt / N;
                automatic int j = col_cnt % N;
                automatic logic [N*W-1:0] exp;
                for (int i = 0; i < N; i++) exp[i*W +: W] = mats[m][i][j];
                check(out_col === exp, "R3/R4 column contents", out_col, exp);
                check(cyc == in_cyc_of[col_cnt] + LAT, "R2/R5 column arrival cycle",
                      (N*W)'(cyc), (N*W)'(in_cyc_of[col_cnt] + LAT));
            end else begin
                check(1'b0, "R7 unexpected column", (N*W)'(col_cnt), (N*W)'(NCOL));
            end
            col_cnt++;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", (N*W)'(col_cnt), (N*W)'(NCOL));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < NMAT; m++)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    mats[m][i][j] = elem(SEED[m], i, j);

        // R1: quiet in reset and after release
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid during reset", (N*W)'(out_valid), '0);
        rst_n = 1'b1;
        repeat (LAT + 2) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 out_valid idle after reset", (N*W)'(out_valid), '0);
        end

        // Table walk: R3..R6 through back-to-back and gapped matrices
        for (int m = 0; m < NMAT - 1; m++) begin
            send_rows(m, N, 1'b1);
            idle(GAP[m]);
        end
        idle(1);
        wait (col_cnt == (NMAT - 1) * N);
        idle(3);
        check(out_valid == 1'b0, "R2 out_valid low once drained", (N*W)'(out_valid), '0);

        // R7: reset in the middle of a matrix drops it
        send_rows(0, N / 2, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R7 out_valid cleared by reset", (N*W)'(out_valid), '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(LAT + 2);
        check(col_cnt == (NMAT - 1) * N, "R7 partial matrix emits nothing",
              (N*W)'(col_cnt), (N*W)'((NMAT - 1) * N));
        send_rows(NMAT - 1, N, 1'b1);
        idle(LAT + 4);

        check(col_cnt == NCOL, "R4/R5 total column count", (N*W)'(col_cnt), (N*W)'(NCOL));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule